// File: doc/BRIEF.md
# Four-Bit Immediate Instruction Processor

This block is a very small processor with three 4-bit registers, R0, R1 and R2. It has no program memory of its own. An outside agent places an 8-bit instruction word on the instruction input and then pulls the active-low activation line down. Each such falling edge runs exactly one instruction. The available operations load an immediate value, combine R0 and R1 into R2, copy R2 back, invert a register into R2, or choose which register the single seven-segment digit shows.

The activation line is asynchronous to the free-running system clock. It passes through a synchroniser and an edge detector, so a line held low does not run the instruction a second time. The digit shows R2 unless a display instruction has chosen R0 or R1. That choice lasts until the next instruction that writes R2. Segment outputs are active low.

Top module: `nibcpu`

## Requirements
- R1: A synchronous active-high reset clears R0, R1 and R2 to zero and selects R2 for display, so the digit shows glyph 0.
- R2: Opcode 000 (instruction bits 7:5) loads bits 3:0 into R0 when bit 4 is 0, or into R1 when bit 4 is 1.
- R3: Opcode 001 sets R2 to R0+R1 and opcode 101 sets R2 to R1-R0, both modulo 16, with no flag kept.
- R4: Opcode 010 sets R2 to R0 AND R1, and opcode 011 sets R2 to R0 OR R1. Bits 4:0 have no effect on these, or on 001 and 101.
- R5: Opcode 100 copies R2 into R0 (bit 4 = 0) or into R1 (bit 4 = 1).
- R6: Opcode 111 sets R2 to the bitwise inverse of R0 (bit 4 = 0) or of R1 (bit 4 = 1).
- R7: Opcode 110 makes the digit show R0 (bit 4 = 0) or R1 (bit 4 = 1). The choice holds until an instruction with opcode 001, 010, 011, 101 or 111 runs, which returns the display to R2. Opcodes 000 and 100 leave the choice unchanged.
- R8: While activation is high, changes on the instruction input alter no register and no display state.
- R9: Each falling edge of activation runs exactly one instruction, sampled two clocks after the edge reaches the synchroniser. Holding activation low runs nothing more, even if the instruction word changes.
- R10: The segment output is active low with segment a..g on bits 0..6. Values 0..15 show hexadecimal glyphs 0-9, A, b, C, d, E, F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| act_n | input | 1 | Activation line, active low, asynchronous |
| instr | input | 8 | Instruction word: opcode 7:5, register select 4, immediate 3:0 |
| seg_n | output | 7 | Active-low segments, a on bit 0 through g on bit 6 |

## Verification
A falling activation edge enters a two-flop synchroniser. The execute pulse is high in the cycle after the second clock edge, and the registers update on the third edge. The segment output is combinational from the registers, so it is valid in that same cycle. The bench keeps activation low for four clocks and then high for four more, and it samples the digit on a falling clock edge after that window. The result is settled well before the sample. R0 and R1 are made visible through display instructions, and a reference model in the bench tracks every register and the display choice.

// File: rtl/nibcpu_pkg.sv
package nibcpu_pkg;
  localparam int WORD_W  = 4;
  localparam int INSTR_W = 8;
  localparam int SEG_W   = 7;
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 3'd0,
    OP_ADD  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_MOVE = 3'd4,
    OP_SUB  = 3'd5,
    OP_SHOW = 3'd6,
    OP_INV  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    VIEW_R2 = 2'd0,
    VIEW_R0 = 2'd1,
    VIEW_R1 = 2'd2
  } view_e;

  typedef struct packed {
    op_e               op;
    logic              rsel;
    logic [WORD_W-1:0] imm;
  } instr_t;

  function automatic logic op_writes_r2(op_e op);
    return (op == OP_ADD) || (op == OP_AND) || (op == OP_OR) ||
           (op == OP_SUB) || (op == OP_INV);
  endfunction
endpackage

// File: rtl/nibcpu_act_edge.sv
module nibcpu_act_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic act_n,
  output logic fire
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              held;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= act_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) held <= 1'b1;
    else     held <= chain[LAST];
  end

  assign fire = held & ~chain[LAST];

  // R9: an execute pulse lasts a single cycle
  p_single_fire_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/nibcpu_alu.sv
module nibcpu_alu
  import nibcpu_pkg::*;
(
  input  op_e               op,
  input  logic              rsel,
  input  logic [WORD_W-1:0] a0,
  input  logic [WORD_W-1:0] a1,
  output logic [WORD_W-1:0] res
);
  logic [WORD_W-1:0] picked;

  assign picked = rsel ? a1 : a0;

  always_comb begin
    unique case (op)
      OP_ADD:  res = a0 + a1;
      OP_SUB:  res = a1 - a0;
      OP_AND:  res = a0 & a1;
      OP_OR:   res = a0 | a1;
      OP_INV:  res = ~picked;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/nibcpu_regs.sv
module nibcpu_regs
  import nibcpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  instr_t            ins,
  output logic [WORD_W-1:0] shown
);
  logic [WORD_W-1:0] gpr [2];
  logic [WORD_W-1:0] r2;
  logic [WORD_W-1:0] alu_res;
  view_e             view;

  nibcpu_alu u_alu (
    .op   (ins.op),
    .rsel (ins.rsel),
    .a0   (gpr[0]),
    .a1   (gpr[1]),
    .res  (alu_res)
  );

  generate
    for (genvar k = 0; k < 2; k++) begin : g_gpr
      always_ff @(posedge clk) begin
        if (rst) begin
          gpr[k] <= '0;
        end else if (fire && (ins.rsel == 1'(k))) begin
          if (ins.op == OP_LOAD)      gpr[k] <= ins.imm;
          else if (ins.op == OP_MOVE) gpr[k] <= r2;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      r2   <= '0;
      view <= VIEW_R2;
    end else if (fire) begin
      if (op_writes_r2(ins.op)) begin
        r2   <= alu_res;
        view <= VIEW_R2;
      end else if (ins.op == OP_SHOW) begin
        view <= ins.rsel ? VIEW_R1 : VIEW_R0;
      end
    end
  end

  always_comb begin
    unique case (view)
      VIEW_R0: shown = gpr[0];
      VIEW_R1: shown = gpr[1];
      default: shown = r2;
    endcase
  end

  // R8: no execute pulse, no state change
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(gpr[0]) && $stable(gpr[1]) && $stable(r2) && $stable(view)));

  // R2: load of R0 takes the immediate
  p_load_r0_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && ins.op == OP_LOAD && !ins.rsel) |=> gpr[0] == $past(ins.imm));

  // R3: addition wraps modulo 16
  p_add_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && ins.op == OP_ADD) |=> r2 == WORD_W'($past(gpr[0]) + $past(gpr[1])));

  // R5: move into R1 copies old R2
  p_move_r1_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && ins.op == OP_MOVE && ins.rsel) |=> gpr[1] == $past(r2));

  // R7: writing R2 returns the display to R2
  p_r2_write_view_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && op_writes_r2(ins.op)) |=> view == VIEW_R2);
endmodule

// File: rtl/nibcpu_seg7.sv
module nibcpu_seg7
  import nibcpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] value,
  output logic [SEG_W-1:0]  seg_n
);
  logic [SEG_W-1:0] lit;

  always_comb begin
    unique case (value)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
  end

  assign seg_n = ~lit;

  // R10: every glyph lights at least two segments
  p_glyph_lit_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(~seg_n) >= 2);
endmodule

// File: rtl/nibcpu.sv
module nibcpu
  import nibcpu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               act_n,
  input  logic [INSTR_W-1:0] instr,
  output logic [SEG_W-1:0]   seg_n
);
  logic              fire;
  logic [WORD_W-1:0] shown;
  instr_t            ins;

  assign ins = instr_t'(instr);

  nibcpu_act_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .act_n (act_n),
    .fire  (fire)
  );

  nibcpu_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .ins   (ins),
    .shown (shown)
  );

  nibcpu_seg7 u_seg (
    .clk   (clk),
    .rst   (rst),
    .value (shown),
    .seg_n (seg_n)
  );
endmodule

// File: tb/tb_nibcpu.sv
module tb_nibcpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       act_n = 1'b1;
  logic [7:0] instr = 8'h00;
  logic [6:0] seg_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [3:0] m0 = 0, m1 = 0, m2 = 0;
  int         mview = 2;

  localparam logic [6:0] GLYPH [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

  always #4 clk = ~clk;

  nibcpu dut (.clk(clk), .rst(rst), .act_n(act_n), .instr(instr), .seg_n(seg_n));

  function automatic logic [6:0] exp_seg();
    logic [3:0] v;
    v = (mview == 0) ? m0 : (mview == 1) ? m1 : m2;
    return ~GLYPH[v];
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1, 3'd5: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd6: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic model(input logic [7:0] w);
    logic [2:0] op;
    logic r;
    op = w[7:5];
    r  = w[4];
    case (op)
      3'd0: if (r) m1 = w[3:0]; else m0 = w[3:0];
      3'd1: begin m2 = m0 + m1; mview = 2; end
      3'd2: begin m2 = m0 & m1; mview = 2; end
      3'd3: begin m2 = m0 | m1; mview = 2; end
      3'd4: if (r) m1 = m2; else m0 = m2;
      3'd5: begin m2 = m1 - m0; mview = 2; end
      3'd6: mview = r ? 1 : 0;
      default: begin m2 = r ? ~m1 : ~m0; mview = 2; end
    endcase
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (seg_n !== exp_seg()) begin
      n_bad++;
      $display("FAIL %s: seg_n=%h expected=%h", tag, seg_n, exp_seg());
    end
  endtask

  task automatic run(input logic [7:0] w, input string tag);
    @(negedge clk);
    instr = w;
    act_n = 1'b0;
    repeat (4) @(negedge clk);
    act_n = 1'b1;
    repeat (4) @(negedge clk);
    model(w);
    check(tag);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1");                       // reset: digit shows 0 from R2

    // directed
    run(8'b000_1_1001, "R2");          // LD R1,9
    run(8'b000_0_0011, "R2");          // LD R0,3
    run(8'b110_0_0000, "R2 R7");       // show R0
    run(8'b110_1_0000, "R2 R7");       // show R1
    run(8'b001_1_1111, "R3 R4");       // add, bits 4:0 ignored -> 12
    run(8'b101_0_0000, "R3");          // 9-3 = 6
    run(8'b000_0_1010, "R7");          // load keeps R2 view
    run(8'b101_0_0000, "R3");          // 9-10 wraps to F
    run(8'b100_1_0000, "R5");          // R1 <- R2
    run(8'b110_1_0000, "R5 R7");
    run(8'b111_0_0000, "R6");          // ~R0
    run(8'b010_0_0000, "R4");
    run(8'b011_0_0000, "R4");
    run(8'b000_1_1111, "R2");
    run(8'b000_0_0001, "R2");
    run(8'b001_0_0000, "R3");          // F+1 wraps to 0

    // R8: activation high, instruction changes ignored
    run(8'b110_1_0000, "R7");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      instr = {3'b000, 1'b1, 4'(i + 3)};
      repeat (3) @(negedge clk);
      check("R8");
    end
    run(8'b110_1_0000, "R8");

    // R9: held low, new word not executed
    @(negedge clk);
    instr = 8'b000_1_0110;
    act_n = 1'b0;
    repeat (4) @(negedge clk);
    model(instr);
    instr = 8'b000_1_1101;
    repeat (10) @(negedge clk);
    act_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9");                       // still showing R1 = 6

    // R10: every glyph
    for (int v = 0; v < 16; v++) begin
      run({3'b000, 1'b0, 4'(v)}, "R10");
      run(8'b110_0_0000, "R10");
    end

    // random
    for (int n = 0; n < 400; n++) begin
      logic [7:0] w;
      w = 8'($urandom());
      run(w, tag_of(w[7:5]));
    end

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m0 = 0; m1 = 0; m2 = 0; mview = 2;
    @(negedge clk);
    check("R1");
    run(8'b110_1_0000, "R1");
    finish_up();
  end
endmodule